// File: doc/BRIEF.md
# Sleep-Mode ECC Retention Controller

This controller takes a DRAM array into and out of a low-power retention mode. On entering, it reads every word once, computes a single-error-correcting Hamming code over the data and writes the check bits back beside it. The array can then ride out a refresh interval eight times the normal one. During that interval the controller gates the peripheral supply between refresh bursts. On leaving, it walks every word again, repairs any single flipped bit, writes the clean word back and counts the repaired words. Only after that does it hand the array back to normal traffic.

While active, host reads and writes pass straight through to the memory port in the same cycle. They get no encoding and no correction. The array itself sits outside the block: a synchronous memory with a one-cycle read latency, holding 136-bit words, attached to the memory port. The word count, the normal refresh interval, the retention multiplier and the burst length are parameters.

Top module: `ersl_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `pwr_gate` is 0, `mem_refresh` is 0 and `err_count` is 0.
- R2: While `ready` is 1, the host signals reach the memory port in the same cycle and `host_rdata` equals `mem_rdata[127:0]` with no correction applied.
- R3: A rise of `sleep_req` in the active state starts an encode walk. The walk reads and then rewrites every address from 0 to WORDS-1, taking two cycles per word, and stores the check bits in `mem_wdata[135:128]`.
- R4: `pwr_gate` is 1 exactly while the controller waits in sleep between bursts. It is 0 during walks, during refresh bursts and in the active state.
- R5: In sleep, `pwr_gate` stays high for RETENTION_MULT*REF_INTERVAL consecutive cycles, and then `mem_refresh` is high for BURST_LEN cycles. This pattern repeats.
- R6: If `sleep_req` falls during a refresh burst, the burst still runs its full BURST_LEN cycles before the decode walk starts.
- R7: The decode walk corrects any single flipped bit in any of the 136 stored positions, check bits included, and writes the corrected word back.
- R8: `err_count` clears at the start of each encode walk. It then holds the number of words whose syndrome was nonzero during the last decode walk.
- R9: `ready` is 0 from the cycle `sleep_req` is 1 until the decode walk ends, and the decode walk takes exactly 2*WORDS cycles. Host requests made while `ready` is 0 do not reach the memory.
- R10: A stored word is `{chk[7:0], data[127:0]}`. Hamming positions 1 to 136 skip the powers of two and are given to data bits 0 to 127 in ascending order. Check bit k is the XOR of the data bits whose position has bit k set. A normal host write stores chk = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Level request: 1 asks for sleep, 0 asks to wake |
| ready | output | 1 | Array available to the host |
| pwr_gate | output | 1 | Peripheral power gate enable |
| mem_refresh | output | 1 | Refresh burst in progress |
| err_count | output | $clog2(WORDS+1) | Words corrected in the last decode walk |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | $clog2(WORDS) | Host word address |
| host_wdata | input | 128 | Host write data |
| host_rdata | output | 128 | Host read data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | $clog2(WORDS) | Memory word address |
| mem_wdata | output | 136 | Memory write word |
| mem_rdata | input | 136 | Memory read word, valid one cycle after a read |

## Verification
The bench flips single bits while the array sleeps. It hits both ends of the data field and both ends of the check field, so a decoder that maps syndromes to the wrong data bits, or that ignores check-bit errors, leaves corrupted words or returns the wrong `err_count`. It drops the wake request in the first cycle of a burst, where a controller that abandons the burst would show a short `mem_refresh` pulse. It also drives host writes while `ready` is low, where a leaky port mux would overwrite stored words. Off-by-one faults in the interval and burst counters show up as gap and burst lengths one cycle wrong. A walk that skips the last address leaves one word unencoded or unrepaired.

// File: rtl/ersl_pkg.sv
// Package: shared state type and code-width helper for the retention controller.
// Assumes: data words of a few hundred bits at most.
package ersl_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_ENCODE,
        ST_SLEEP,
        ST_REFRESH,
        ST_DECODE
    } ersl_state_e;

    // Smallest number of Hamming check bits r with 2^r >= data + r + 1.
    function automatic int chk_bits(input int data_w);
        int r;
        r = 1;
        while ((1 << r) < data_w + r + 1) r++;
        return r;
    endfunction

endpackage

// File: rtl/ersl_ham_enc.sv
// Hamming check-bit generator.
// Data bits fill the non-power-of-two positions 1..CODE_W in ascending order.
// Check bit k is the parity of every data bit whose position has bit k set.
module ersl_ham_enc import ersl_pkg::*; #(
    parameter  int DATA_W = 128,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);

    // Purpose: fold every data bit into the parity groups its position selects.
    always_comb begin
        int d;
        chk = '0;
        d   = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int k = 0; k < CHK_W; k++) begin
                    if (((p >> k) & 1) == 1) chk[k] = chk[k] ^ data[d];
                end
                d++;
            end
        end
    end

endmodule

// File: rtl/ersl_ham_dec.sv
// Single-error corrector.
// It takes the stored word and freshly recomputed check bits.
// A zero syndrome means a clean word. A power-of-two syndrome points at a check bit.
// Any other in-range syndrome points at the data bit at that Hamming position.
module ersl_ham_dec import ersl_pkg::*; #(
    parameter  int DATA_W = 128,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  chk_in,
    input  logic [CHK_W-1:0]  chk_calc,
    output logic [DATA_W-1:0] data_out,
    output logic [CHK_W-1:0]  chk_out,
    output logic              corrected
);

    logic [CHK_W-1:0] syndrome;
    logic             chk_hit;

    assign syndrome  = chk_in ^ chk_calc;
    assign chk_hit   = (syndrome != '0) && ((syndrome & (syndrome - 1'b1)) == '0);
    assign corrected = (syndrome != '0) && (int'(syndrome) <= CODE_W);
    // A check-bit error leaves the data alone, so the recomputed bits are the right ones.
    assign chk_out   = chk_hit ? chk_calc : chk_in;

    // Purpose: flip the data bit whose Hamming position equals the syndrome.
    always_comb begin
        int d;
        data_out = data_in;
        d        = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (int'(syndrome) == p) data_out[d] = ~data_in[d];
                d++;
            end
        end
    end

endmodule

// File: rtl/ersl_sleep_timer.sv
// Sleep interval and refresh burst timer.
// One counter serves both phases and restarts at every phase change.
// Assumes run and burst are never high together.
module ersl_sleep_timer #(
    parameter  int SLEEP_CYC = 512,
    parameter  int BURST_CYC = 16,
    localparam int LIMIT     = (SLEEP_CYC > BURST_CYC) ? SLEEP_CYC : BURST_CYC,
    localparam int CNT_W     = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic burst,
    output logic interval_up,
    output logic burst_done
);

    logic [CNT_W-1:0] cnt;

    assign interval_up = run   && (cnt == CNT_W'(SLEEP_CYC - 1));
    assign burst_done  = burst && (cnt == CNT_W'(BURST_CYC - 1));

    // Purpose: count cycles of the current phase and clear at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt <= '0;
        else if (interval_up || burst_done)          cnt <= '0;
        else if (run || burst)                       cnt <= cnt + 1'b1;
        else                                         cnt <= '0;
    end

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LIMIT));

endmodule

// File: rtl/ersl_ctrl.sv
// Top of the retention controller.
// A level sleep request starts an encode walk, then sleep with gated refresh bursts.
// Dropping the request starts a decode walk that repairs single-bit errors.
// Host traffic passes through only while ready is high.
// Assumes a synchronous memory with one-cycle read latency on the mem_* port.
module ersl_ctrl import ersl_pkg::*; #(
    parameter  int WORDS          = 4096,
    parameter  int DATA_W         = 128,
    parameter  int REF_INTERVAL   = 64,
    parameter  int RETENTION_MULT = 8,
    parameter  int BURST_LEN      = 16,
    localparam int CHK_W          = chk_bits(DATA_W),
    localparam int CODE_W         = DATA_W + CHK_W,
    localparam int ADDR_W         = $clog2(WORDS),
    localparam int CNT_W          = $clog2(WORDS + 1),
    localparam int SLEEP_CYC      = REF_INTERVAL * RETENTION_MULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    output logic              ready,
    output logic              pwr_gate,
    output logic              mem_refresh,
    output logic [CNT_W-1:0]  err_count,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CODE_W-1:0] mem_wdata,
    input  logic [CODE_W-1:0] mem_rdata
);

    ersl_state_e       state;
    logic              wr_phase;
    logic [ADDR_W-1:0] walk_addr;
    logic              last_word;
    logic              walking;
    logic              interval_up;
    logic              burst_done;
    logic [CHK_W-1:0]  chk_calc;
    logic [DATA_W-1:0] fix_data;
    logic [CHK_W-1:0]  fix_chk;
    logic              fix_hit;

    assign last_word   = (walk_addr == ADDR_W'(WORDS - 1));
    assign walking     = (state == ST_ENCODE) || (state == ST_DECODE);
    assign ready       = (state == ST_ACTIVE) && !sleep_req;
    assign pwr_gate    = (state == ST_SLEEP);
    assign mem_refresh = (state == ST_REFRESH);
    assign host_rdata  = mem_rdata[DATA_W-1:0];

    ersl_ham_enc #(.DATA_W(DATA_W)) u_enc (
        .data (mem_rdata[DATA_W-1:0]),
        .chk  (chk_calc)
    );

    ersl_ham_dec #(.DATA_W(DATA_W)) u_dec (
        .data_in   (mem_rdata[DATA_W-1:0]),
        .chk_in    (mem_rdata[CODE_W-1:DATA_W]),
        .chk_calc  (chk_calc),
        .data_out  (fix_data),
        .chk_out   (fix_chk),
        .corrected (fix_hit)
    );

    ersl_sleep_timer #(.SLEEP_CYC(SLEEP_CYC), .BURST_CYC(BURST_LEN)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (state == ST_SLEEP),
        .burst       (state == ST_REFRESH),
        .interval_up (interval_up),
        .burst_done  (burst_done)
    );

    // Purpose: sequence the mode states, the two-cycle word walk and the repair count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_ACTIVE;
            wr_phase  <= 1'b0;
            walk_addr <= '0;
            err_count <= '0;
        end else begin
            case (state)
                ST_ACTIVE: if (sleep_req) begin
                    state     <= ST_ENCODE;
                    wr_phase  <= 1'b0;
                    walk_addr <= '0;
                    err_count <= '0;
                end
                ST_ENCODE, ST_DECODE: begin
                    wr_phase <= ~wr_phase;
                    if (wr_phase) begin
                        if (state == ST_DECODE && fix_hit) err_count <= err_count + 1'b1;
                        if (last_word) begin
                            walk_addr <= '0;
                            state     <= (state == ST_ENCODE) ? ST_SLEEP : ST_ACTIVE;
                        end else begin
                            walk_addr <= walk_addr + 1'b1;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (!sleep_req)       state <= ST_DECODE;
                    else if (interval_up) state <= ST_REFRESH;
                end
                ST_REFRESH: if (burst_done) state <= sleep_req ? ST_SLEEP : ST_DECODE;
                default: state <= ST_ACTIVE;
            endcase
        end
    end

    // Purpose: steer the memory port to the walk, to the host, or to idle.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (walking) begin
            mem_en    = 1'b1;
            mem_we    = wr_phase;
            mem_addr  = walk_addr;
            mem_wdata = (state == ST_ENCODE) ? {chk_calc, mem_rdata[DATA_W-1:0]}
                                             : {fix_chk, fix_data};
        end else if (ready) begin
            mem_en    = host_en;
            mem_we    = host_we;
            mem_addr  = host_addr;
            mem_wdata = {{CHK_W{1'b0}}, host_wdata};
        end
    end

    a_r4_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_gate |-> (!mem_en && !mem_refresh));

    a_r6_burst_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFRESH && !burst_done) |=> (state == ST_REFRESH));

    a_r9_ready_after_decode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(state == ST_DECODE));

    a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        walk_addr <= ADDR_W'(WORDS - 1));

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |=> (err_count == $past(err_count) ||
                                  err_count == $past(err_count) + 1'b1));

endmodule

// File: tb/ersl_ctrl_test.sv
module ersl_ctrl_test;

    localparam int WORDS   = 16;
    localparam int REF_INT = 4;
    localparam int MULT    = 8;
    localparam int BURST   = 3;
    localparam int SLP     = REF_INT * MULT;
    localparam int AW      = $clog2(WORDS);
    localparam int CW      = $clog2(WORDS + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sleep_req = 1'b0;
    logic           ready, pwr_gate, mem_refresh;
    logic [CW-1:0]  err_count;
    logic           host_en = 1'b0, host_we = 1'b0;
    logic [AW-1:0]  host_addr = '0;
    logic [127:0]   host_wdata = '0;
    logic [127:0]   host_rdata;
    logic           mem_en, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [135:0]   mem_wdata;
    logic [135:0]   mem_rdata = '0;

    logic [135:0]   mem  [WORDS];
    logic [127:0]   gold [WORDS];

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ersl_ctrl #(.WORDS(WORDS), .DATA_W(128), .REF_INTERVAL(REF_INT),
                .RETENTION_MULT(MULT), .BURST_LEN(BURST)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ready(ready),
        .pwr_gate(pwr_gate), .mem_refresh(mem_refresh), .err_count(err_count),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata));

    // Synchronous memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    function automatic logic [7:0] exp_chk(input logic [127:0] d);
        logic [7:0] c;
        int idx;
        c = '0;
        idx = 0;
        for (int p = 1; p <= 136; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int k = 0; k < 8; k++) if (((p >> k) & 1) == 1) c[k] ^= d[idx];
                idx++;
            end
        end
        return c;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [127:0] d);
        host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
        gold[a] = d;
    endtask

    task automatic host_read(input int a, output logic [127:0] d);
        host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] rd;
        int g, b, n_inj;
        void'($urandom(32'd2024));
        for (int i = 0; i < WORDS; i++) begin mem[i] = '0; gold[i] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", ready, 1);
        check("R1 pwr_gate", pwr_gate, 0);
        check("R1 refresh", mem_refresh, 0);
        check("R1 err_count", err_count, 0);

        // R10: normal writes store zero check bits
        for (int i = 0; i < WORDS; i++) host_write(i, rnd128());
        for (int i = 0; i < WORDS; i += 5) check("R10 chk zero", mem[i][135:128], 0);

        // R2: same-cycle pass-through and plain readback
        host_en = 1'b1; host_we = 1'b0; host_addr = AW'(7);
        #1;
        check("R2 pass-through", {mem_en, mem_we, mem_addr}, {1'b1, 1'b0, AW'(7)});
        @(negedge clk); host_en = 1'b0;
        check("R2 readback", host_rdata, gold[7]);
        mem[5][9] = ~mem[5][9];
        host_read(5, rd);
        check("R2 no correction", rd, gold[5] ^ (128'd1 << 9));
        mem[5][9] = ~mem[5][9];

        // Round 1: sleep with injected errors, wake during a burst
        sleep_req = 1'b1;
        #1 check("R9 ready drops", ready, 0);
        while (!pwr_gate) @(negedge clk);
        for (int i = 0; i < WORDS; i++) begin
            check("R3 encoded word", mem[i], {exp_chk(gold[i]), gold[i]});
        end
        mem[0][128] = ~mem[0][128];
        mem[1][135] = ~mem[1][135];
        mem[2][0]   = ~mem[2][0];
        mem[3][127] = ~mem[3][127];
        n_inj = 4;
        for (int i = 4; i < 10; i++) begin
            int bit_pos;
            bit_pos = int'($urandom % 136);
            mem[i][bit_pos] = ~mem[i][bit_pos];
            n_inj++;
        end
        g = 0;
        while (pwr_gate) begin g++; @(negedge clk); end
        check("R5 sleep gap", g, SLP);
        check("R5 burst start", mem_refresh, 1);
        b = 0;
        while (mem_refresh) begin
            if (pwr_gate) check("R4 gate off in burst", pwr_gate, 0);
            b++; @(negedge clk);
        end
        check("R5 burst length", b, BURST);
        check("R4 gate back on", pwr_gate, 1);
        while (!mem_refresh) @(negedge clk);
        sleep_req = 1'b0;
        b = 0;
        while (mem_refresh) begin b++; @(negedge clk); end
        check("R6 burst completes", b, BURST);
        check("R4 gate off in decode", pwr_gate, 0);
        g = 0;
        while (!ready) begin g++; @(negedge clk); end
        check("R9 decode length", g, 2 * WORDS);
        for (int i = 0; i < WORDS; i++) begin
            check("R7 repaired word", mem[i], {exp_chk(gold[i]), gold[i]});
        end
        check("R8 err_count", err_count, n_inj);

        // Round 2: no errors, wake in plain sleep, host pokes ignored while not ready
        host_write(2, rnd128());
        host_write(11, rnd128());
        sleep_req = 1'b1;
        @(negedge clk);
        check("R8 count cleared", err_count, 0);
        host_en = 1'b1; host_we = 1'b1; host_addr = AW'(11); host_wdata = ~gold[11];
        while (!pwr_gate) @(negedge clk);
        sleep_req = 1'b0;
        while (!ready) @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
        check("R9 host ignored", mem[11][127:0], gold[11]);
        check("R8 zero errors", err_count, 0);
        host_read(2, rd);
        check("R2 readback after wake", rd, gold[2]);
        check("R4 gate off active", pwr_gate, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule